// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches sixteen asynchronous request lines and one non-maskable line coming from outside the chip. Every request line is first brought into the clock domain through a two-stage synchroniser. Each line can then be set to one of four ways of recognising a request: an active-low level, an active-high level, a rising edge or a falling edge. When a line's chosen condition is seen, a sticky per-channel flag is set. Software clears a flag by writing zero to its bit. A mask register selects which flags drive the single combined interrupt output.

The non-maskable line has a fixed behaviour that the per-channel modes do not affect. In normal operation a falling edge produces a one-cycle request pulse. While the stop-mode input is high, the line is treated as an active-low level instead, so a wake-up request is held for as long as the pin stays low.

Software reaches the block through a small register port. Writes take effect on a clock edge, and reads are combinational. Addresses 0 and 1 hold the mode words, address 2 holds the flags and address 3 holds the enables.

Top module: `ext_irq_detector`

## Requirements
- R1: After reset, both mode words, the flag word and the enable word read as zero, and `irq_out` and `nmi_req` are low. The synchroniser stages reset to 1, so an idle high line raises no flag.
- R2: Mode word 0 (address 0) holds channels 0 to 7 and mode word 1 (address 1) holds channels 8 to 15. Channel x uses bit 2(x mod 8)+1 as the upper mode bit and bit 2(x mod 8) as the lower mode bit. Both words read back what was written.
- R3: Mode code 2'b00 sets the flag while the synchronised input is low, and code 2'b01 sets it while the input is high. An input at its idle level sets nothing.
- R4: Mode code 2'b10 sets the flag on a rising edge of the synchronised input, and code 2'b11 sets it on a falling edge. The opposite edge and a steady input set nothing.
- R5: In either level mode, a flag cleared while its input is still active is set again, so it reads back as 1.
- R6: The flag word is at address 2. A written 0 clears the corresponding flag and a written 1 leaves it unchanged. An edge-mode flag stays clear after clearing while its input is steady.
- R7: When a clear and a new detection meet on the same clock edge, the flag ends up set.
- R8: The enable word is at address 3. `irq_out` is high exactly when some channel has both its flag and its enable bit set.
- R9: While `stop_mode` is low, a falling edge on `nmi_in` gives a `nmi_req` pulse one cycle long, whatever the channel modes are.
- R10: While `stop_mode` is high, `nmi_req` stays high for as long as the synchronised `nmi_in` is low, and drops once it is high again.
- R11: Rewriting a channel's mode while its input is steady does not set its flag.
- R12: An input change first shows in a flag, or in `nmi_req`, after the third rising clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_in | input | 16 | Asynchronous external request lines |
| nmi_in | input | 1 | Asynchronous non-maskable request line |
| stop_mode | input | 1 | High while the chip is in the stop state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq_out | output | 1 | OR of all enabled flags |
| nmi_req | output | 1 | Non-maskable request |

## Verification
A software clear of the flag word and a fresh hardware detection on the same channel can fall on the same clock edge. The bench provokes this in two ways. First, it times a clear-all write so that it lands on the edge where a falling-edge channel's flag is due to rise, and then checks that the flag reads 1. Second, in every level-mode pass of the channel and mode sweep, it clears the flag while the input is held active, which also places detection and clear on one edge. Edge-mode channels serve as the contrast: they must read 0 after the same clear.

// File: rtl/eid_pkg.sv
package eid_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_RISE = 2'b10,
    MODE_FALL = 2'b11
  } det_mode_e;

  localparam int unsigned MODE_BITS = 2;

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      stab_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/eid_chan_detect.sv
module eid_chan_detect
  import eid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      samp,
  input  det_mode_e mode,
  output logic      hit
);

  logic prev_q;
  logic prev_d;

  // Previous sample follows the input every cycle regardless of mode,
  // so a mode rewrite never fabricates an edge.
  always_comb prev_d = samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  always_comb begin
    unique case (mode)
      MODE_LOW:  hit = ~samp;
      MODE_HIGH: hit = samp;
      MODE_RISE: hit = samp & ~prev_q;
      MODE_FALL: hit = ~samp & prev_q;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/eid_nmi_detect.sv
module eid_nmi_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_raw,
  input  logic stop_mode,
  output logic nmi_req
);

  logic nmi_s;
  logic prev_q;
  logic req_q;
  logic req_d;

  eid_sync #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nmi_raw),
    .q     (nmi_s)
  );

  always_comb begin
    if (stop_mode) req_d = ~nmi_s;
    else           req_d = prev_q & ~nmi_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      prev_q <= nmi_s;
      req_q  <= req_d;
    end
  end

  assign nmi_req = req_q;

  // R9: an edge-mode request never lasts two cycles
  assert_nmi_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !$past(stop_mode) && !stop_mode) |=> !nmi_req);

  // R10: in stop, a low synchronised line holds the request
  assert_nmi_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !nmi_s) |=> nmi_req);

endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
  import eid_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] req_in,
  input  logic              nmi_in,
  input  logic              stop_mode,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out,
  output logic              nmi_req
);

  localparam int unsigned NUM_CH     = DATA_W;
  localparam int unsigned CH_PER_REG = DATA_W / MODE_BITS;
  localparam int unsigned NUM_MREG   = NUM_CH / CH_PER_REG;
  localparam logic [1:0]  ADDR_FLAGS = 2'(NUM_MREG);
  localparam logic [1:0]  ADDR_EN    = 2'(NUM_MREG + 1);

  logic [DATA_W-1:0] mode_q [NUM_MREG];
  logic [DATA_W-1:0] mode_d [NUM_MREG];
  logic [NUM_MREG-1:0] mode_we;
  logic [NUM_CH-1:0] flags_q, flags_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              en_we;
  logic              clr_en;
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] req_s;
  logic [NUM_CH-1:0] hits;

  eid_sync #(.W(NUM_CH), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_in),
    .q     (req_s)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    eid_chan_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .samp  (req_s[i]),
      .mode  (det_mode_e'(mode_q[i / CH_PER_REG][MODE_BITS*(i % CH_PER_REG) +: MODE_BITS])),
      .hit   (hits[i])
    );
  end

  eid_nmi_detect u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_raw   (nmi_in),
    .stop_mode (stop_mode),
    .nmi_req   (nmi_req)
  );

  // Next-state logic
  always_comb begin
    for (int k = 0; k < NUM_MREG; k++) begin
      mode_we[k] = wr_en && (wr_addr == 2'(k));
      mode_d[k]  = wr_data;
    end
    en_we    = wr_en && (wr_addr == ADDR_EN);
    en_d     = wr_data;
    clr_en   = wr_en && (wr_addr == ADDR_FLAGS);
    clr_mask = clr_en ? ~wr_data : '0;
    // detection takes precedence over a simultaneous clear
    flags_d  = (flags_q & ~clr_mask) | hits;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_MREG; k++) mode_q[k] <= '0;
      en_q    <= '0;
      flags_q <= '0;
    end else begin
      for (int k = 0; k < NUM_MREG; k++) begin
        if (mode_we[k]) mode_q[k] <= mode_d[k];
      end
      if (en_we) en_q <= en_d;
      flags_q <= flags_d;
    end
  end

  // Read mux
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_MREG; k++) begin
      if (rd_addr == 2'(k)) rd_data = mode_q[k];
    end
    if (rd_addr == ADDR_FLAGS) rd_data = flags_q;
    if (rd_addr == ADDR_EN)    rd_data = en_q;
  end

  assign irq_out = |(flags_q & en_q);

  // R6: without a flag write, no flag falls
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!clr_en) |-> (($past(flags_q) & ~flags_q) == '0));

  // R7: every detected channel is flagged on the next cycle, clear or not
  assert_hit_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |=> (($past(hits) & ~flags_q) == '0));

  // R8: writing an all-zero enable word silences the interrupt output
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && (wr_addr == ADDR_EN) && (wr_data == '0)) |-> !irq_out);

endmodule

// File: tb/ext_irq_detector_tb.sv
module ext_irq_detector_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req_in;
  logic        nmi_in;
  logic        stop_mode;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        irq_out;
  logic        nmi_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ext_irq_detector u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .nmi_in(nmi_in),
    .stop_mode(stop_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_out(irq_out), .nmi_req(nmi_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  function automatic logic idle_lvl(input int m);
    return (m == 0 || m == 3) ? 1'b1 : 1'b0;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_in = 16'hFFFF; nmi_in = 1'b1; stop_mode = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq_out in reset", 32'(irq_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd_chk("R1 mode0", 2'd0, 16'h0);
    rd_chk("R1 mode1", 2'd1, 16'h0);
    rd_chk("R1 flags", 2'd2, 16'h0);
    rd_chk("R1 enable", 2'd3, 16'h0);
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 nmi_req", 32'(nmi_req), 0);

    // R2 readback of both mode words
    wr(2'd0, 16'hA5C3);
    rd_chk("R2 mode0 readback", 2'd0, 16'hA5C3);
    wr(2'd1, 16'h3C5A);
    rd_chk("R2 mode1 readback", 2'd1, 16'h3C5A);
    wr(2'd0, 16'h0); wr(2'd1, 16'h0);
    repeat (4) @(negedge clk);
    wr(2'd2, 16'h0);
    rd_chk("R2 flags after restore", 2'd2, 16'h0);

    // Sweep: every channel in every mode (R2, R3, R4, R5, R6, R8, R12)
    for (int ch = 0; ch < 16; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] bit_ch;
        logic [1:0]  mreg;
        bit_ch = 16'h1 << ch;
        mreg   = 2'(ch / 8);
        req_in[ch] = idle_lvl(m);
        wr(mreg, 16'(m) << (2 * (ch % 8)));
        repeat (4) @(negedge clk);
        wr(2'd2, 16'h0);
        rd_chk($sformatf("R3 R4 idle ch%0d mode%0d", ch, m), 2'd2, 16'h0);
        req_in[ch] = ~idle_lvl(m);
        @(negedge clk);
        @(negedge clk);
        rd_chk($sformatf("R12 not yet ch%0d mode%0d", ch, m), 2'd2, 16'h0);
        @(negedge clk);
        rd_chk($sformatf("R2 R3 R4 R12 detect ch%0d mode%0d", ch, m), 2'd2, bit_ch);
        chk("R8 irq masked", 32'(irq_out), 0);
        wr(2'd3, bit_ch);
        chk("R8 irq enabled", 32'(irq_out), 1);
        wr(2'd3, ~bit_ch);
        chk("R8 irq other enables", 32'(irq_out), 0);
        wr(2'd3, 16'h0);
        wr(2'd2, 16'hFFFF);
        rd_chk("R6 write one keeps", 2'd2, bit_ch);
        wr(2'd2, 16'h0);
        if (m < 2) begin
          rd_chk($sformatf("R5 level reassert ch%0d", ch), 2'd2, bit_ch);
        end else begin
          rd_chk($sformatf("R6 edge cleared ch%0d", ch), 2'd2, 16'h0);
          repeat (3) @(negedge clk);
          rd_chk($sformatf("R4 steady no retrigger ch%0d", ch), 2'd2, 16'h0);
        end
        req_in[ch] = 1'b1;
        wr(mreg, 16'h0);
        repeat (4) @(negedge clk);
        wr(2'd2, 16'h0);
      end
    end

    // R7: clear lands on the edge a falling-edge detection sets the flag
    wr(2'd0, 16'(3) << 10);
    repeat (4) @(negedge clk);
    wr(2'd2, 16'h0);
    req_in[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R7 detection beats clear", 2'd2, 16'h0020);
    wr(2'd2, 16'h0);
    rd_chk("R7 later clear works", 2'd2, 16'h0);
    req_in[5] = 1'b1;
    wr(2'd0, 16'h0);
    repeat (4) @(negedge clk);
    wr(2'd2, 16'h0);

    // R11: mode rewrite with a steady high input
    wr(2'd0, 16'(2) << 6);
    repeat (4) @(negedge clk);
    rd_chk("R11 to rising no flag", 2'd2, 16'h0);
    wr(2'd0, 16'(3) << 6);
    repeat (4) @(negedge clk);
    rd_chk("R11 to falling no flag", 2'd2, 16'h0);
    wr(2'd0, 16'h0);

    // R9: NMI falling edge, with all channels in falling-edge mode
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF);
    nmi_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 nmi not yet", 32'(nmi_req), 0);
    @(negedge clk);
    chk("R9 nmi pulse", 32'(nmi_req), 1);
    @(negedge clk);
    chk("R9 nmi pulse one cycle", 32'(nmi_req), 0);
    repeat (3) @(negedge clk);
    chk("R9 nmi steady low ignored", 32'(nmi_req), 0);
    nmi_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 nmi rising ignored", 32'(nmi_req), 0);
    rd_chk("R9 channel flags untouched", 2'd2, 16'h0);
    wr(2'd0, 16'h0); wr(2'd1, 16'h0);

    // R10: level sensing in stop mode
    stop_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 stop idle", 32'(nmi_req), 0);
    nmi_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 not yet", 32'(nmi_req), 0);
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      chk("R10 held while low", 32'(nmi_req), 1);
    end
    nmi_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 still held", 32'(nmi_req), 1);
    @(negedge clk);
    chk("R10 released", 32'(nmi_req), 0);
    stop_mode = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule